// File: doc/BRIEF.md
# Final Trigger Energy Combiner

This block is the last summing stage of a calorimeter trigger tree. It takes five partial energy sums, already formed upstream, from three detector sections. The endcap sends one six-patch sum. The west barrel and the east barrel each send a four-patch sum and a two-patch sum. From these it forms the total energy at full precision and a small set of group trigger bits.

Neighbouring partial sums are added into 1x2 groups, and the four barrel sums are added into one 2x2 group. Each group is tested against a programmable threshold. A software-written table of four entries chooses which sections take part. The entry is selected by two request bits. A section that is masked off adds nothing to any sum and keeps every group it belongs to from firing.

Inputs are captured in an alignment register together with the looked-up mask and the thresholds. Results appear in an output register one cycle later, so the block is a two-register pipeline.

Top module: `trig_energy_combiner`

## Requirements
- R1: While reset is asserted and after its release, `out_vld`, `tot_energy`, `tot_over`, `pair_hit` and `quad_hit` are zero. Every table entry resets to mask 3'b111, which enables all sections.
- R2: A sample presented with `in_vld` high at a clock edge appears with `out_vld` high exactly two edges later. When `out_vld` is low, all result outputs keep their previous values.
- R3: `tot_energy` is the sum of the enabled partial sums. It is wide enough that the all-ones case (3*16383 + 2*8191 = 65531) is represented exactly.
- R4: `tot_over` is 1 exactly when `tot_energy` is strictly greater than `thr_total`. Equality gives 0.
- R5: `pair_hit[i]` is 1 when the 1x2 group i is strictly above `thr_pair` and both of its sections are enabled. The groups are: bit 0 endcap + west four-patch, bit 1 west four-patch + west two-patch, bit 2 east four-patch + east two-patch, bit 3 west four-patch + east four-patch, bit 4 west two-patch + east two-patch.
- R6: `quad_hit` is 1 when the sum of the four barrel partial sums is strictly above `thr_quad` and both barrel sections are enabled.
- R7: The table entry used for a sample is indexed by {`sel_ec`,`sel_br`}. Mask bit 0 enables the endcap, bit 1 the west barrel and bit 2 the east barrel. A write of `lut_mask` to entry `lut_idx` with `lut_we` high at one edge applies to samples captured at later edges.
- R8: A masked-off section contributes zero to `tot_energy`. It forces to 0 every `pair_hit` bit and the `quad_hit` bit whose group includes that section, whatever its input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Partial sums and selector are valid this cycle |
| ec_sum | input | 14 | Endcap six-patch partial sum |
| wb_sum4 | input | 14 | West barrel four-patch partial sum |
| wb_sum2 | input | 13 | West barrel two-patch partial sum |
| eb_sum4 | input | 14 | East barrel four-patch partial sum |
| eb_sum2 | input | 13 | East barrel two-patch partial sum |
| sel_ec | input | 1 | Endcap request bit, upper table index bit |
| sel_br | input | 1 | Barrel request bit, lower table index bit |
| lut_we | input | 1 | Table write strobe |
| lut_idx | input | 2 | Table entry to write |
| lut_mask | input | 3 | Section mask to write |
| thr_pair | input | 15 | 1x2 group threshold |
| thr_quad | input | 16 | 2x2 group threshold |
| thr_total | input | 17 | Total energy threshold |
| out_vld | output | 1 | Result registers updated this cycle |
| tot_energy | output | 17 | Total enabled energy |
| tot_over | output | 1 | Total strictly above threshold |
| pair_hit | output | 5 | 1x2 group hits |
| quad_hit | output | 1 | 2x2 group hit |

## Verification
The threshold assertions compare the registered results against the threshold ports as they stand when the result comes out. They therefore assume that the thresholds do not change while a sample is in the pipeline. The stimulus only changes thresholds after several idle cycles, once the pipeline is empty. The assertions also assume that every in-flight sample was fully captured after reset release. The stimulus starts issuing samples only once reset has been deasserted for at least one edge.

// File: rtl/tec_pkg.sv
package tec_pkg;
  localparam int NSEC  = 3;
  localparam int NPART = 5;
  localparam int NPAIR = 5;
  localparam int NLUT  = 4;

  // partial order: 0 endcap, 1 west 4-patch, 2 west 2-patch, 3 east 4-patch, 4 east 2-patch
  localparam int PART_SEC [NPART] = '{0, 1, 1, 2, 2};
  localparam int PAIR_LO  [NPAIR] = '{0, 1, 3, 1, 2};
  localparam int PAIR_HI  [NPAIR] = '{1, 2, 4, 3, 4};

  typedef logic [NSEC-1:0] sec_mask_t;
endpackage

// File: rtl/tec_enable_lut.sv
module tec_enable_lut
  import tec_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NLUT)-1:0] wr_idx,
  input  sec_mask_t               wr_mask,
  input  logic [$clog2(NLUT)-1:0] rd_idx,
  output sec_mask_t               rd_mask
);
  sec_mask_t entry_q [NLUT];

  for (genvar e = 0; e < NLUT; e++) begin : g_entry
    logic      wen;
    sec_mask_t entry_d;
    always_comb begin
      wen     = wr_en && (wr_idx == e);
      entry_d = wr_mask;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   entry_q[e] <= '1;
      else if (wen) entry_q[e] <= entry_d;
    end
  end

  assign rd_mask = entry_q[rd_idx];
endmodule

// File: rtl/tec_in_align.sv
module tec_in_align
  import tec_pkg::*;
#(
  parameter int W_WIDE   = 14,
  parameter int W_NARROW = 13,
  localparam int PW = W_WIDE + 1,
  localparam int QW = W_WIDE + 2,
  localparam int TW = W_WIDE + 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           vld_i,
  input  logic [W_WIDE-1:0]              ec_i,
  input  logic [W_WIDE-1:0]              wb4_i,
  input  logic [W_NARROW-1:0]            wb2_i,
  input  logic [W_WIDE-1:0]              eb4_i,
  input  logic [W_NARROW-1:0]            eb2_i,
  input  sec_mask_t                      mask_i,
  input  logic [PW-1:0]                  thr_pair_i,
  input  logic [QW-1:0]                  thr_quad_i,
  input  logic [TW-1:0]                  thr_total_i,
  output logic                           vld_o,
  output logic [NPART-1:0][W_WIDE-1:0]   part_o,
  output sec_mask_t                      mask_o,
  output logic [PW-1:0]                  thr_pair_o,
  output logic [QW-1:0]                  thr_quad_o,
  output logic [TW-1:0]                  thr_total_o
);
  logic [NPART-1:0][W_WIDE-1:0] part_d;

  always_comb begin
    part_d[0] = ec_i;
    part_d[1] = wb4_i;
    part_d[2] = W_WIDE'(wb2_i);
    part_d[3] = eb4_i;
    part_d[4] = W_WIDE'(eb2_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_o <= 1'b0;
    else        vld_o <= vld_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_o      <= '0;
      mask_o      <= '0;
      thr_pair_o  <= '0;
      thr_quad_o  <= '0;
      thr_total_o <= '0;
    end else if (vld_i) begin
      part_o      <= part_d;
      mask_o      <= mask_i;
      thr_pair_o  <= thr_pair_i;
      thr_quad_o  <= thr_quad_i;
      thr_total_o <= thr_total_i;
    end
  end
endmodule

// File: rtl/tec_combine.sv
module tec_combine
  import tec_pkg::*;
#(
  parameter int W_WIDE = 14,
  localparam int PW = W_WIDE + 1,
  localparam int QW = W_WIDE + 2,
  localparam int TW = W_WIDE + 3
) (
  input  logic [NPART-1:0][W_WIDE-1:0] part_i,
  input  sec_mask_t                    mask_i,
  input  logic [PW-1:0]                thr_pair_i,
  input  logic [QW-1:0]                thr_quad_i,
  input  logic [TW-1:0]                thr_total_i,
  output logic [TW-1:0]                total_o,
  output logic                         total_over_o,
  output logic [NPAIR-1:0]             pair_hit_o,
  output logic                         quad_hit_o
);
  logic [NPART-1:0][W_WIDE-1:0] gated;
  logic [QW-1:0]                quad_sum;

  always_comb begin
    total_o = '0;
    for (int i = 0; i < NPART; i++) begin
      gated[i] = mask_i[PART_SEC[i]] ? part_i[i] : '0;
      total_o  = total_o + TW'(gated[i]);
    end
    total_over_o = total_o > thr_total_i;
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic [PW-1:0] sum;
    logic          ok;
    always_comb begin
      sum           = PW'(gated[PAIR_LO[p]]) + PW'(gated[PAIR_HI[p]]);
      ok            = mask_i[PART_SEC[PAIR_LO[p]]] & mask_i[PART_SEC[PAIR_HI[p]]];
      pair_hit_o[p] = ok && (sum > thr_pair_i);
    end
  end

  always_comb begin
    quad_sum   = QW'(gated[1]) + QW'(gated[2]) + QW'(gated[3]) + QW'(gated[4]);
    quad_hit_o = mask_i[1] && mask_i[2] && (quad_sum > thr_quad_i);
  end
endmodule

// File: rtl/trig_energy_combiner.sv
module trig_energy_combiner
  import tec_pkg::*;
#(
  parameter int W_WIDE   = 14,
  parameter int W_NARROW = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_vld,
  input  logic [W_WIDE-1:0]     ec_sum,
  input  logic [W_WIDE-1:0]     wb_sum4,
  input  logic [W_NARROW-1:0]   wb_sum2,
  input  logic [W_WIDE-1:0]     eb_sum4,
  input  logic [W_NARROW-1:0]   eb_sum2,
  input  logic                  sel_ec,
  input  logic                  sel_br,
  input  logic                  lut_we,
  input  logic [1:0]            lut_idx,
  input  logic [2:0]            lut_mask,
  input  logic [W_WIDE:0]       thr_pair,
  input  logic [W_WIDE+1:0]     thr_quad,
  input  logic [W_WIDE+2:0]     thr_total,
  output logic                  out_vld,
  output logic [W_WIDE+2:0]     tot_energy,
  output logic                  tot_over,
  output logic [4:0]            pair_hit,
  output logic                  quad_hit
);
  localparam int PW = W_WIDE + 1;
  localparam int QW = W_WIDE + 2;
  localparam int TW = W_WIDE + 3;

  sec_mask_t                    lut_rd_mask;
  logic                         s1_vld;
  logic [NPART-1:0][W_WIDE-1:0] s1_part;
  sec_mask_t                    s1_mask;
  logic [PW-1:0]                s1_thr_pair;
  logic [QW-1:0]                s1_thr_quad;
  logic [TW-1:0]                s1_thr_total;
  logic [TW-1:0]                c_total;
  logic                         c_over;
  logic [NPAIR-1:0]             c_pair;
  logic                         c_quad;

  tec_enable_lut u_lut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (lut_we),
    .wr_idx  (lut_idx),
    .wr_mask (lut_mask),
    .rd_idx  ({sel_ec, sel_br}),
    .rd_mask (lut_rd_mask)
  );

  tec_in_align #(.W_WIDE(W_WIDE), .W_NARROW(W_NARROW)) u_align (
    .clk         (clk),
    .rst_n       (rst_n),
    .vld_i       (in_vld),
    .ec_i        (ec_sum),
    .wb4_i       (wb_sum4),
    .wb2_i       (wb_sum2),
    .eb4_i       (eb_sum4),
    .eb2_i       (eb_sum2),
    .mask_i      (lut_rd_mask),
    .thr_pair_i  (thr_pair),
    .thr_quad_i  (thr_quad),
    .thr_total_i (thr_total),
    .vld_o       (s1_vld),
    .part_o      (s1_part),
    .mask_o      (s1_mask),
    .thr_pair_o  (s1_thr_pair),
    .thr_quad_o  (s1_thr_quad),
    .thr_total_o (s1_thr_total)
  );

  tec_combine #(.W_WIDE(W_WIDE)) u_comb (
    .part_i       (s1_part),
    .mask_i       (s1_mask),
    .thr_pair_i   (s1_thr_pair),
    .thr_quad_i   (s1_thr_quad),
    .thr_total_i  (s1_thr_total),
    .total_o      (c_total),
    .total_over_o (c_over),
    .pair_hit_o   (c_pair),
    .quad_hit_o   (c_quad)
  );

  // output stage: next-state and register split
  logic [TW-1:0]    tot_d;
  logic             over_d;
  logic [NPAIR-1:0] pair_d;
  logic             quad_d;

  always_comb begin
    tot_d  = c_total;
    over_d = c_over;
    pair_d = c_pair;
    quad_d = c_quad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= s1_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_energy <= '0;
      tot_over   <= 1'b0;
      pair_hit   <= '0;
      quad_hit   <= 1'b0;
    end else if (s1_vld) begin
      tot_energy <= tot_d;
      tot_over   <= over_d;
      pair_hit   <= pair_d;
      quad_hit   <= quad_d;
    end
  end
endmodule

// File: rtl/tec_checker.sv
module tec_checker #(
  parameter int W_WIDE = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [W_WIDE:0]   thr_pair,
  input logic [W_WIDE+1:0] thr_quad,
  input logic [W_WIDE+2:0] thr_total,
  input logic              out_vld,
  input logic [W_WIDE+2:0] tot_energy,
  input logic              tot_over,
  input logic [4:0]        pair_hit,
  input logic              quad_hit
);
  localparam int TW = W_WIDE + 3;

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> ##1 out_vld);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ##1 !out_vld);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> ($stable(tot_energy) && $stable(tot_over) && $stable(pair_hit) && $stable(quad_hit)));

  p_total_over_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (tot_over == (tot_energy > thr_total)));

  p_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && (pair_hit != '0)) |-> (tot_energy > TW'(thr_pair)));

  p_quad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && quad_hit) |-> (tot_energy > TW'(thr_quad)));
endmodule

bind trig_energy_combiner tec_checker #(.W_WIDE(W_WIDE)) u_chk (.*);

// File: tb/sim_trig_energy_combiner.sv
module sim_trig_energy_combiner;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [16:0] tot;
    logic        over;
    logic [4:0]  pair;
    logic        quad;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [13:0] ec_sum, wb_sum4, eb_sum4;
  logic [12:0] wb_sum2, eb_sum2;
  logic        sel_ec, sel_br, lut_we;
  logic [1:0]  lut_idx;
  logic [2:0]  lut_mask;
  logic [14:0] thr_pair;
  logic [15:0] thr_quad;
  logic [16:0] thr_total;
  logic        out_vld, tot_over, quad_hit;
  logic [16:0] tot_energy;
  logic [4:0]  pair_hit;

  int   n_chk = 0, n_fail = 0;
  bit   done = 0;
  exp_t sb_q[$];
  logic [2:0] mlut [4];
  exp_t last;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_energy_combiner u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic exp_t model(input [13:0] e, w4, input [12:0] w2, input [13:0] x4,
                                 input [12:0] x2, input [2:0] m);
    exp_t r;
    logic [16:0] ge, gw4, gw2, gx4, gx2;
    ge  = m[0] ? 17'(e)  : 17'd0;
    gw4 = m[1] ? 17'(w4) : 17'd0;
    gw2 = m[1] ? 17'(w2) : 17'd0;
    gx4 = m[2] ? 17'(x4) : 17'd0;
    gx2 = m[2] ? 17'(x2) : 17'd0;
    r.tot     = ge + gw4 + gw2 + gx4 + gx2;
    r.over    = r.tot > thr_total;
    r.pair[0] = m[0] && m[1] && ((ge + gw4) > 17'(thr_pair));
    r.pair[1] = m[1] && ((gw4 + gw2) > 17'(thr_pair));
    r.pair[2] = m[2] && ((gx4 + gx2) > 17'(thr_pair));
    r.pair[3] = m[1] && m[2] && ((gw4 + gx4) > 17'(thr_pair));
    r.pair[4] = m[1] && m[2] && ((gw2 + gx2) > 17'(thr_pair));
    r.quad    = m[1] && m[2] && ((gw4 + gw2 + gx4 + gx2) > 17'(thr_quad));
    return r;
  endfunction

  task automatic send(input [13:0] e, w4, input [12:0] w2, input [13:0] x4,
                      input [12:0] x2, input bit se, input bit sb);
    @(negedge clk);
    ec_sum = e; wb_sum4 = w4; wb_sum2 = w2; eb_sum4 = x4; eb_sum2 = x2;
    sel_ec = se; sel_br = sb; in_vld = 1'b1;
    sb_q.push_back(model(e, w4, w2, x4, x2, mlut[{se, sb}]));
  endtask

  task automatic send_rand(input bit se, input bit sb);
    send(14'($urandom_range(0, 16383)), 14'($urandom_range(0, 16383)),
         13'($urandom_range(0, 8191)), 14'($urandom_range(0, 16383)),
         13'($urandom_range(0, 8191)), se, sb);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  task automatic set_thr(input [14:0] p, input [15:0] q, input [16:0] t);
    idle(4);
    thr_pair = p; thr_quad = q; thr_total = t;
  endtask

  task automatic lut_wr(input [1:0] idx, input [2:0] m);
    @(negedge clk);
    in_vld = 1'b0;
    lut_we = 1'b1; lut_idx = idx; lut_mask = m;
    mlut[idx] = m;
    @(negedge clk);
    lut_we = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (out_vld) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R2 unexpected out_vld", 1, 0);
        end else begin
          exp_t x;
          x = sb_q.pop_front();
          chk(tot_energy == x.tot, "R3/R8 tot_energy", tot_energy, x.tot);
          chk(tot_over == x.over, "R4 tot_over", tot_over, x.over);
          chk(pair_hit == x.pair, "R5/R8 pair_hit", pair_hit, x.pair);
          chk(quad_hit == x.quad, "R6/R8 quad_hit", quad_hit, x.quad);
        end
        last = '{tot_energy, tot_over, pair_hit, quad_hit};
      end else begin
        chk({tot_energy, tot_over, pair_hit, quad_hit} == last, "R2 hold when idle",
            {tot_energy, tot_over, pair_hit, quad_hit}, last);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mlut[i] = 3'b111;
    last = '0;
    rst_n = 1'b0; in_vld = 1'b0; lut_we = 1'b0; lut_idx = '0; lut_mask = '0;
    ec_sum = '0; wb_sum4 = '0; wb_sum2 = '0; eb_sum4 = '0; eb_sum2 = '0;
    sel_ec = 1'b0; sel_br = 1'b0;
    thr_pair = 15'd10000; thr_quad = 16'd20000; thr_total = 17'd30000;
    repeat (3) @(negedge clk);
    chk(out_vld == 1'b0, "R1 reset out_vld", out_vld, 0);
    chk(tot_energy == '0, "R1 reset tot_energy", tot_energy, 0);
    chk({tot_over, pair_hit, quad_hit} == '0, "R1 reset flags", {tot_over, pair_hit, quad_hit}, 0);
    rst_n = 1'b1;
    idle(2);

    // R1 R7: default table enables everything for every selector
    for (int s = 0; s < 4; s++) send_rand(s[1], s[0]);
    idle(3);

    // R3: worst-case sum
    send(14'h3FFF, 14'h3FFF, 13'h1FFF, 14'h3FFF, 13'h1FFF, 1'b1, 1'b1);
    idle(3);

    // R4 boundary: equal then one above
    send(14'd10000, 14'd10000, 13'd5000, 14'd5000, 13'd0, 1'b0, 1'b0);
    send(14'd10000, 14'd10000, 13'd5000, 14'd5000, 13'd1, 1'b0, 1'b0);
    idle(3);

    // R5 R6 boundaries
    set_thr(15'd2000, 16'd4000, 17'd100000);
    send(14'd1000, 14'd1000, 13'd1000, 14'd1000, 13'd1000, 1'b1, 1'b1);
    send(14'd1000, 14'd1001, 13'd1000, 14'd1000, 13'd1001, 1'b1, 1'b1);
    idle(3);
    set_thr(15'd10000, 16'd20000, 17'd30000);

    // R7 R8: masks per entry, used right after the write
    lut_wr(2'b10, 3'b001);
    send(14'd16000, 14'd9000, 13'd8000, 14'd9000, 13'd8000, 1'b1, 1'b0);
    lut_wr(2'b01, 3'b110);
    send(14'd16000, 14'd9000, 13'd8000, 14'd9000, 13'd8000, 1'b0, 1'b1);
    lut_wr(2'b00, 3'b000);
    send(14'd16000, 14'd9000, 13'd8000, 14'd9000, 13'd8000, 1'b0, 1'b0);
    lut_wr(2'b11, 3'b101);
    send(14'd16000, 14'd9000, 13'd8000, 14'd9000, 13'd8000, 1'b1, 1'b1);
    send(14'd16000, 14'd9000, 13'd8000, 14'd9000, 13'd8000, 1'b1, 1'b0);
    idle(3);
    lut_wr(2'b11, 3'b011);
    send(14'd12000, 14'd12000, 13'd100, 14'd12000, 13'd100, 1'b1, 1'b1);
    idle(3);

    // mixed back-to-back traffic with gaps
    for (int k = 0; k < 40; k++) begin
      send_rand(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(6);
    chk(sb_q.size() == 0, "R2 all samples delivered", sb_q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule